// File: doc/BRIEF.md
# Fractional Clock Divider with Selectable Noise Shaping

This block derives a slower clock from its input clock by letting only some input edges through. Each output period lasts a whole number of input cycles. That length is the programmed integer divisor plus a small offset, which changes from one period to the next. Over a long run the average period equals the integer divisor plus a 12-bit fraction divided by 4096. A fraction of 2048 therefore adds one half of an input cycle to the average period.

The offset comes from a modulator built from cascaded 12-bit accumulators. An order input picks how many accumulator stages take part:

- Order 0 ignores the fraction.
- Orders 1, 2 and 3 give first-, second- and third-order noise shaping.
- A higher order pushes more of the period jitter to high frequency, but it also widens the spread of the periods.

The modulator steps once per output period. Each output period starts high and ends low, so the duty cycle is close to 50%.

A run input starts and stops the output. When run falls, the period in progress completes and the output then stays low. The accumulators are cleared, so every start replays the same period sequence.

Top module: `mash_clkdiv`

## Requirements
- R1: With order 0 (`order` = 2'd0), every output period is exactly the integer divisor D in input cycles, whatever the value of `divf`.
- R2: With order 0 and D = 1, `clk_out` follows `clk` while running: it is high while `clk` is high and low while `clk` is low.
- R3: Each output period of P cycles starts with a rising edge of `clk_out`. The output is high for the first ceil(P/2) cycles and low for the remaining floor(P/2) cycles.
- R4: At order 1 the modulator uses one accumulator. At each period start, a1 ← a1 + F modulo 4096, and the carry c1 out of that sum gives a period of D + c1. Over the first 4096 periods after a start, the total length is exactly 4096·D + F.
- R5: At order 2 a second accumulator adds in the new a1 value, giving carry c2. The period is D + c1 + c2 − c2', where c2' is c2 of the previous period. Every period lies in [D−1, D+2].
- R6: At order 3 a third accumulator adds in the new a2 value, giving carry c3. The period is D + c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' and '' mark the values from one and two periods earlier. Every period lies in [D−3, D+4]. Over 4096 periods the total differs from 4096·D + F by at most 2.
- R7: D is raised to the minimum for its order when programmed below it. The minimums are 1 for order 0, 2 for order 1, 3 for order 2 and 5 for order 3, so a `divi` of 0 at order 0 divides by 1.
- R8: After `run` is first sampled high at a clock edge, `clk_out` is high in the following cycle.
- R9: When `run` is sampled low, the current period completes, including when the sample falls on the last cycle of the period. No new period starts, and `clk_out` then stays low.
- R10: Accumulators and carry history are all zero at every start, so a restart produces the same period sequence as the first run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input (source) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start/keep running when high; stop after the current period when low |
| divi | input | 12 | Integer divisor D |
| divf | input | 12 | Fraction F, weight F/4096 |
| order | input | 2 | Noise-shaping order 0..3 |
| clk_out | output | 1 | Divided output clock |

## Verification
Two things can land on the same clock edge: the stop request and the period boundary where the next period would load. The bench provokes this by dropping `run` so that it is sampled exactly at the edge where the counter wraps. It then expects one full high phase, one rising edge and a permanently low output afterwards. A second case drops `run` in the middle of a period, and the reload of periods with `run` held high is judged against a scoreboard of model periods.

// File: rtl/mash_clkdiv.sv
module mash_clkdiv #(
  parameter int DW = 12,
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] divi,
  input  logic [FW-1:0] divf,
  input  logic [1:0]    order,
  output logic          clk_out
);
  localparam int PW = DW + 1;

  logic          act_q, byp_q, out_q;
  logic [PW-1:0] cnt_q, per_q;
  logic [DW-1:0] dve_q;
  logic [1:0]    ord_q;
  logic [FW-1:0] a1_q, a2_q, a3_q;
  logic          c2d_q, c3d_q, c3dd_q;

  logic [FW:0] s1, s2, s3;
  assign s1 = {1'b0, a1_q} + {1'b0, divf};
  assign s2 = {1'b0, a2_q} + {1'b0, s1[FW-1:0]};
  assign s3 = {1'b0, a3_q} + {1'b0, s2[FW-1:0]};

  logic signed [3:0] e1, e2, e3, d2, d3, d3d, off;
  assign e1  = {3'b000, s1[FW]};
  assign e2  = {3'b000, s2[FW]};
  assign e3  = {3'b000, s3[FW]};
  assign d2  = {3'b000, c2d_q};
  assign d3  = {3'b000, c3d_q};
  assign d3d = {3'b000, c3dd_q};

  always_comb begin
    case (order)
      2'd0:    off = 4'sd0;
      2'd1:    off = e1;
      2'd2:    off = e1 + e2 - d2;
      default: off = e1 + e2 - d2 + e3 - (d3 <<< 1) + d3d;
    endcase
  end

  logic [DW-1:0] dmin, dve;
  always_comb begin
    case (order)
      2'd0:    dmin = DW'(1);
      2'd1:    dmin = DW'(2);
      2'd2:    dmin = DW'(3);
      default: dmin = DW'(5);
    endcase
  end
  assign dve = (divi < dmin) ? dmin : divi;

  logic [PW-1:0] per_n, cnt_m1;
  assign per_n  = {1'b0, dve} + {{(PW-4){off[3]}}, off};
  assign cnt_m1 = cnt_q - PW'(1);

  logic wrap, load;
  assign wrap = act_q ? (cnt_q == '0) : run;
  assign load = wrap && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      byp_q  <= 1'b0;
      out_q  <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
      dve_q  <= '0;
      ord_q  <= '0;
      a1_q   <= '0;
      a2_q   <= '0;
      a3_q   <= '0;
      c2d_q  <= 1'b0;
      c3d_q  <= 1'b0;
      c3dd_q <= 1'b0;
    end else if (load) begin
      act_q  <= 1'b1;
      out_q  <= 1'b1;
      byp_q  <= (per_n == PW'(1));
      cnt_q  <= per_n - PW'(1);
      per_q  <= per_n;
      dve_q  <= dve;
      ord_q  <= order;
      a1_q   <= s1[FW-1:0];
      a2_q   <= s2[FW-1:0];
      a3_q   <= s3[FW-1:0];
      c2d_q  <= s2[FW];
      c3d_q  <= s3[FW];
      c3dd_q <= c3d_q;
    end else if (wrap) begin
      act_q  <= 1'b0;
      out_q  <= 1'b0;
      byp_q  <= 1'b0;
      cnt_q  <= '0;
      a1_q   <= '0;
      a2_q   <= '0;
      a3_q   <= '0;
      c2d_q  <= 1'b0;
      c3d_q  <= 1'b0;
      c3dd_q <= 1'b0;
    end else if (act_q) begin
      cnt_q <= cnt_m1;
      out_q <= (cnt_m1 >= (per_q >> 1));
    end
  end

  assign clk_out = out_q & (clk | ~byp_q);
endmodule

// File: rtl/mash_clkdiv_chk.sv
module mash_clkdiv_chk #(
  parameter int DW = 12,
  parameter int PW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_out,
  input logic          act_q,
  input logic [PW-1:0] cnt_q,
  input logic [PW-1:0] per_q,
  input logic [DW-1:0] dve_q,
  input logic [1:0]    ord_q
);
  logic [PW-1:0] dv;
  assign dv = {1'b0, dve_q};

  AST_ORD0_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ord_q == 2'd0) |-> per_q == dv); // R1
  AST_ORD1_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ord_q == 2'd1) |-> (per_q == dv || per_q == dv + PW'(1))); // R4
  AST_ORD2_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ord_q == 2'd2) |-> (per_q + PW'(1) >= dv && per_q <= dv + PW'(2))); // R5
  AST_ORD3_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ord_q == 2'd3) |-> (per_q + PW'(3) >= dv && per_q <= dv + PW'(4))); // R6
  AST_MIN_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (dve_q >= (ord_q == 2'd3 ? DW'(5) : DW'(ord_q) + DW'(1)))); // R7
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !clk_out); // R9
  AST_PERIOD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != '0) |=> (act_q && cnt_q == $past(cnt_q) - PW'(1))); // R9
endmodule

bind mash_clkdiv mash_clkdiv_chk #(.DW(DW), .PW(DW + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_out(clk_out), .act_q(act_q),
  .cnt_q(cnt_q), .per_q(per_q), .dve_q(dve_q), .ord_q(ord_q)
);

// File: tb/mash_clkdiv_bench.sv
module mash_clkdiv_bench;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [11:0] divi = '0, divf = '0;
  logic [1:0] order = '0;
  wire clk_out;

  always #10 clk = ~clk;

  mash_clkdiv u_mash_clkdiv (
    .clk(clk), .rst_n(rst_n), .run(run), .divi(divi), .divf(divf),
    .order(order), .clk_out(clk_out)
  );

  int checks = 0, fails = 0;
  int exp_q[$];
  bit checking = 0, have_rise = 0, prev = 0;
  string tag = "R1";
  int cyc = 0, hi = 0;
  longint meas_sum = 0;

  task automatic check(string t, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (clk_out && !prev) begin
      if (have_rise && checking) begin
        if (exp_q.size() == 0) check({tag, " extra period"}, 0, cyc, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(tag, cyc == e, cyc, e);
          check("R3 high time", hi == (e + 1) / 2, hi, (e + 1) / 2);
          meas_sum += cyc;
        end
      end
      have_rise = 1;
      cyc = 1;
      hi = 1;
    end else begin
      cyc++;
      if (clk_out) hi++;
    end
    prev = clk_out;
  end

  bit hi_en = 0, pv2 = 0;
  int hi_total = 0, rises = 0;
  always @(negedge clk) begin
    if (hi_en) begin
      if (clk_out) hi_total++;
      if (clk_out && !pv2) rises++;
    end
    pv2 = clk_out;
  end

  int m1, m2, m3, mc2d, mc3d, mc3dd;

  function int dmin(int o);
    return (o == 0) ? 1 : (o == 1) ? 2 : (o == 2) ? 3 : 5;
  endfunction

  function int next_period(int o, int d, int f);
    int c1, c2, c3, off;
    m1 = m1 + f;  c1 = m1 >> 12; m1 = m1 & 4095;
    m2 = m2 + m1; c2 = m2 >> 12; m2 = m2 & 4095;
    m3 = m3 + m2; c3 = m3 >> 12; m3 = m3 & 4095;
    case (o)
      0: off = 0;
      1: off = c1;
      2: off = c1 + c2 - mc2d;
      default: off = c1 + c2 - mc2d + c3 - 2 * mc3d + mc3dd;
    endcase
    mc2d = c2; mc3dd = mc3d; mc3d = c3;
    return d + off;
  endfunction

  task automatic run_seq(int o, int d, int f, int n, string t, output longint got, output longint want);
    int de;
    @(posedge clk); #1;
    order = 2'(o); divi = 12'(d); divf = 12'(f);
    m1 = 0; m2 = 0; m3 = 0; mc2d = 0; mc3d = 0; mc3dd = 0;
    de = (d < dmin(o)) ? dmin(o) : d;
    want = 0;
    for (int i = 0; i < n; i++) begin
      int p;
      p = next_period(o, de, f);
      exp_q.push_back(p);
      want += p;
    end
    meas_sum = 0; have_rise = 0; tag = t; checking = 1; run = 1;
    while (exp_q.size() != 0) @(posedge clk);
    #1; checking = 0; run = 0;
    got = meas_sum;
    repeat (2 * de + 20) @(posedge clk);
    @(negedge clk);
    check({t, " R9 idle after stop"}, clk_out == 1'b0, clk_out, 0);
  endtask

  task automatic stop_case(int d, int w, int exp_hi, string t);
    @(posedge clk); #1;
    order = 2'd0; divi = 12'(d); divf = '0;
    hi_total = 0; rises = 0; hi_en = 1; run = 1;
    do @(negedge clk); while (clk_out !== 1'b1);
    repeat (w) @(posedge clk);
    #1 run = 0;
    repeat (4 * d + 10) @(posedge clk);
    #1 hi_en = 0;
    check({t, " high cycles"}, hi_total == exp_hi, hi_total, exp_hi);
    check({t, " single period"}, rises == 1, rises, 1);
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    longint got, want;
    repeat (3) @(negedge clk);
    check("reset output low", clk_out == 1'b0, clk_out, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (2) @(posedge clk);

    // R8: start timing
    #1; order = 2'd0; divi = 12'd4; divf = '0; run = 1;
    @(negedge clk);
    check("R8 low before first edge", clk_out == 1'b0, clk_out, 0);
    @(negedge clk);
    check("R8 high after start edge", clk_out == 1'b1, clk_out, 1);
    @(posedge clk); #1 run = 0;
    repeat (12) @(posedge clk);

    // R1: order 0 ignores fraction
    run_seq(0, 7, 2048, 20, "R1 order0", got, want);
    check("R1 total", got == want, got, want);
    run_seq(0, 2, 4095, 20, "R1 order0 d2", got, want);

    // R2: divide by one passes the clock through
    @(posedge clk); #1; order = 2'd0; divi = 12'd1; run = 1;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      #5 check("R2 high phase", clk_out == 1'b1, clk_out, 1);
      @(negedge clk); #5 check("R2 low phase", clk_out == 1'b0, clk_out, 0);
      @(posedge clk);
    end
    #1 run = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R2 R9 low after stop", clk_out == 1'b0, clk_out, 0);

    // R7: divisor 0 at order 0 behaves as 1
    @(posedge clk); #1; order = 2'd0; divi = 12'd0; run = 1;
    repeat (3) @(posedge clk);
    #5 check("R7 d0 high phase", clk_out == 1'b1, clk_out, 1);
    @(negedge clk); #5 check("R7 d0 low phase", clk_out == 1'b0, clk_out, 0);
    @(posedge clk); #1 run = 0;
    repeat (5) @(posedge clk);

    // R4: first order, full 4096-period window
    run_seq(1, 2, 1117, 4096, "R4 order1", got, want);
    check("R4 exact total", got == 64'(4096 * 2 + 1117), got, 4096 * 2 + 1117);
    run_seq(1, 9, 2048, 40, "R4 order1 half", got, want);
    check("R4 half total", got == want, got, want);
    // R10: restart replays from cleared state
    run_seq(1, 9, 2048, 40, "R10 restart", got, want);

    // R5: second order
    run_seq(2, 3, 3001, 4096, "R5 order2", got, want);
    check("R5 total near", (got - (4096 * 3 + 3001)) <= 2 && (got - (4096 * 3 + 3001)) >= -2, got, 4096 * 3 + 3001);

    // R6: third order
    run_seq(3, 5, 1234, 4096, "R6 order3", got, want);
    check("R6 total near", (got - (4096 * 5 + 1234)) <= 2 && (got - (4096 * 5 + 1234)) >= -2, got, 4096 * 5 + 1234);
    run_seq(3, 40, 4095, 100, "R6 order3 d40", got, want);

    // R7: clamping
    run_seq(1, 0, 0, 20, "R7 order1 clamp", got, want);
    run_seq(2, 1, 3000, 60, "R7 order2 clamp", got, want);
    run_seq(3, 2, 1000, 60, "R7 order3 clamp", got, want);

    // R9: stop mid-period and stop on the wrapping edge
    stop_case(6, 1, 3, "R9 mid stop");
    stop_case(4, 3, 2, "R9 stop at wrap");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule